// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind the flag detector and bit destuffer of an HDLC receiver and decides, frame by frame, whether the received frame belongs to this station. It takes the first two bytes of each frame as the address. It compares that address with four host-programmed 16-bit station addresses, using one shared care-mask. If any of the four agrees on every cared-for bit, the address bytes and the rest of the frame go on to the receive buffer path. Otherwise the frame is dropped in full.

Both 8-bit and 16-bit addressing use the same logic. For 8-bit operation the host clears the upper half of the mask, so only the first address byte takes part. Loading 0xFFFF into one address slot gives a broadcast address. The block keeps a saturating count of dropped frames that ended without error, and the host can clear that count. CRC checking happens upstream, and its verdict arrives on `rx_good` with the end-of-frame strobe.

Output bytes leave one byte position behind the input. The newest byte is always held back, and the final byte goes out in the cycle after the end-of-frame strobe, marked by `out_last`.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After synchronous reset the mask is 0xFFFF, all four address slots are 0x0000, the counter is 0, and `out_valid` and `out_last` are low.
- R2: A host write with `cfg_we` high loads `cfg_wdata` into the mask when `cfg_sel` is 0, and into address slot k when `cfg_sel` is k (1 to 4).
- R3: A frame matches when `((addr ^ slot) & mask) == 0` holds for at least one of the four slots; a mask bit of 1 means the position is compared.
- R4: The 16-bit address is formed with the first frame byte (the one with `rx_sof`) as bits 7:0 and the second byte as bits 15:8, so 0x68 then 0xAA gives 0xAA68.
- R5: A matching frame is sent out whole and in order, starting with the two address bytes. Each output byte is registered. The last byte is output in the cycle after `rx_eof`, with `out_last` high in that cycle only.
- R6: A non-matching frame produces no output bytes and no `out_last`.
- R7: When a non-matching frame ends (`rx_eof`) with `rx_good` high, the counter increments by one. With `rx_good` low it does not change.
- R8: With mask 0x00FF, only the first address byte decides the match, whatever the second byte and the slots' upper bytes hold.
- R9: A frame that ends before its second byte arrives gives no output and does not change the counter, even with `rx_good` high.
- R10: The counter saturates at its all-ones value instead of wrapping.
- R11: `cnt_clr` sets the counter to 0 on the next edge, and takes priority over an increment in the same cycle.
- R12: A byte with `rx_sof` always starts a new frame and discards the frame in progress, without counting or flushing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | SEL_W (3) | Register select: 0 mask, 1..N_ADDR address slots |
| cfg_wdata | input | 16 | Host write data |
| cnt_clr | input | 1 | Synchronous clear of the reject counter |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, a cycle with no byte |
| rx_good | input | 1 | Frame error-free, sampled with rx_eof |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of an accepted frame |
| nm_count | output | CNT_W (16) | Count of error-free rejected frames |

## Verification
The hardest state to reach is the saturation corner. With the default width it would take tens of thousands of frames, so the bench builds the block with a 4-bit counter and feeds it short rejected frames until the count sticks at fifteen. It then asserts the clear in the same cycle as a further countable end-of-frame. The other awkward case is a new frame start that arrives while a rejected frame is still open. The bench reaches it by sending two non-matching bytes with no end strobe and then a matching frame, so that both the restart and the absence of a count are observed at the ports.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDR2 = 2'd1,
    S_PASS  = 2'd2,
    S_DROP  = 2'd3
  } filt_state_t;
endpackage

// File: rtl/hdlc_af_regs.sv
module hdlc_af_regs
  import hdlc_af_pkg::*;
#(
  parameter int N_ADDR = 4,
  parameter int SEL_W  = $clog2(N_ADDR + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [SEL_W-1:0]               sel,
  input  logic [ADDR_W-1:0]              wdata,
  output logic [ADDR_W-1:0]              mask,
  output logic [N_ADDR-1:0][ADDR_W-1:0]  slots
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else if (we && sel == '0) mask <= wdata;
  end

  for (genvar i = 0; i < N_ADDR; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slots[i] <= '0;
      else if (we && sel == SEL_W'(i + 1)) slots[i] <= wdata;
    end
  end
endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
#(
  parameter int N_ADDR = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ADDR_W-1:0]              mask,
  input  logic [N_ADDR-1:0][ADDR_W-1:0]  slots,
  output logic                           any_hit
);
  logic [N_ADDR-1:0] hit;

  for (genvar i = 0; i < N_ADDR; i++) begin : g_cmp
    assign hit[i] = ((addr ^ slots[i]) & mask) == '0;
  end

  assign any_hit = |hit;
endmodule

// File: rtl/hdlc_af_cnt.sv
module hdlc_af_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int N_ADDR = 4,
  parameter int CNT_W  = 16,
  localparam int SEL_W = $clog2(N_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              cnt_clr,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic              rx_good,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  nm_count
);
  logic [ADDR_W-1:0]             mask;
  logic [N_ADDR-1:0][ADDR_W-1:0] slots;
  logic [BYTE_W-1:0]             hold;
  logic                          any_hit;
  logic                          cnt_inc;
  filt_state_t                   st;

  hdlc_af_regs #(.N_ADDR(N_ADDR), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .mask(mask), .slots(slots)
  );

  // first byte is the low half of the address
  hdlc_af_match #(.N_ADDR(N_ADDR)) u_match (
    .addr({rx_data, hold}), .mask(mask), .slots(slots), .any_hit(any_hit)
  );

  assign cnt_inc = rx_eof && rx_good && (st == S_DROP);

  hdlc_af_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .count(nm_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      hold      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (rx_eof) begin
        if (st == S_PASS) begin
          out_valid <= 1'b1;
          out_data  <= hold;
          out_last  <= 1'b1;
        end
        st <= S_IDLE;
      end else if (rx_valid && rx_sof) begin
        hold <= rx_data;
        st   <= S_ADDR2;
      end else if (rx_valid) begin
        case (st)
          S_ADDR2: begin
            if (any_hit) begin
              out_valid <= 1'b1;
              out_data  <= hold;
              hold      <= rx_data;
              st        <= S_PASS;
            end else begin
              st <= S_DROP;
            end
          end
          S_PASS: begin
            out_valid <= 1'b1;
            out_data  <= hold;
            hold      <= rx_data;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             rx_valid,
  input logic             rx_eof,
  input logic             out_valid,
  input logic             out_last,
  input logic [CNT_W-1:0] nm_count
);
  // R5: the end marker only travels with a byte
  p_last_with_byte_r5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R5/R6: output bytes only follow an input byte or end strobe
  p_no_spurious_out_r5: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !rx_eof) |=> !out_valid);

  // R7: counter moves only at an end of frame
  p_cnt_only_eof_r7: assert property (@(posedge clk) disable iff (rst)
    (!rx_eof && !cnt_clr) |=> $stable(nm_count));

  // R7/R10: at most one step, never a wrap
  p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> (nm_count == $past(nm_count)) ||
                 (nm_count == CNT_W'($past(nm_count) + 1'b1) && nm_count != '0));

  // R11: clear wins
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> nm_count == '0);
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .rx_valid(rx_valid),
  .rx_eof(rx_eof), .out_valid(out_valid), .out_last(out_last),
  .nm_count(nm_count)
);

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int SEL_W      = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic [15:0]      cfg_wdata = '0;
  logic             cnt_clr = 1'b0;
  logic             rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]       rx_data = '0;
  logic             out_valid, out_last;
  logic [7:0]       out_data;
  logic [CNT_W-1:0] nm_count;

  int checks = 0, failures = 0, exp_cnt = 0, last_seen = 0;
  logic [7:0] got[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_addr_filter #(.N_ADDR(4), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cnt_clr(cnt_clr), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_data(rx_data), .rx_eof(rx_eof), .rx_good(rx_good),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .nm_count(nm_count)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) got.push_back(out_data);
    if (!rst && out_last) last_seen++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SEL_W'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit sof);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = sof; rx_data = d;
  endtask

  task automatic put_eof(input bit good, input bit clr);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1; rx_good = good; cnt_clr = clr;
    @(negedge clk);
    rx_eof = 1'b0; rx_good = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, input int n, input bit good);
    got.delete(); last_seen = 0;
    for (int i = 0; i < n; i++)
      put_byte(i == 0 ? b0 : i == 1 ? b1 : i == 2 ? b2 : b3, i == 0);
    put_eof(good, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_out(input logic [7:0] b0, b1, b2, b3, input int n, input string tag);
    bit ok = (got.size() == n) && (last_seen == (n > 0 ? 1 : 0));
    for (int i = 0; i < n && i < got.size(); i++)
      if (got[i] != (i == 0 ? b0 : i == 1 ? b1 : i == 2 ? b2 : b3)) ok = 0;
    check(ok, tag, got.size(), n);
  endtask

  task automatic expect_cnt(input string tag);
    check(nm_count == CNT_W'(exp_cnt), tag, nm_count, exp_cnt);
  endtask

  task automatic t_reset;
    check(!out_valid && !out_last, "R1 outputs idle", out_valid, 0);
    check(nm_count == 0, "R1 counter zero", nm_count, 0);
    frame(8'h00, 8'h00, 8'h5A, 8'h00, 3, 1'b1);  // reset slots 0 with mask FFFF
    expect_out(8'h00, 8'h00, 8'h5A, 8'h00, 3, "R1 reset slot 0000 matches");
  endtask

  task automatic t_match16;
    wr(1, 16'hAA68); wr(2, 16'hFFFF); wr(3, 16'h1234); wr(4, 16'h0BAD);
    frame(8'h68, 8'hAA, 8'h44, 8'h11, 4, 1'b1);
    expect_out(8'h68, 8'hAA, 8'h44, 8'h11, 4, "R4 R5 16-bit match slot1");
    frame(8'hAA, 8'h68, 8'h44, 8'h11, 4, 1'b1);
    exp_cnt++;
    expect_out(0, 0, 0, 0, 0, "R4 byte order swapped rejected");
    expect_cnt("R7 count after good reject");
    frame(8'hFF, 8'hFF, 8'h01, 8'h00, 3, 1'b1);
    expect_out(8'hFF, 8'hFF, 8'h01, 8'h00, 3, "R3 broadcast slot2");
    frame(8'h34, 8'h12, 8'h00, 8'h00, 2, 1'b1);
    expect_out(8'h34, 8'h12, 0, 0, 2, "R2 R3 slot3 address only");
    frame(8'hAD, 8'h0B, 8'h77, 8'h00, 3, 1'b1);
    expect_out(8'hAD, 8'h0B, 8'h77, 0, 3, "R2 R3 slot4");
  endtask

  task automatic t_reject_bad;
    frame(8'h01, 8'h02, 8'h03, 8'h00, 3, 1'b0);
    expect_out(0, 0, 0, 0, 0, "R6 reject bad no output");
    expect_cnt("R7 no count on errored frame");
  endtask

  task automatic t_mask;
    wr(0, 16'hFF7F); // bit 7 ignored
    frame(8'hE8, 8'hAA, 8'h09, 8'h00, 3, 1'b1);
    expect_out(8'hE8, 8'hAA, 8'h09, 0, 3, "R3 masked bit differs still matches");
    frame(8'h69, 8'hAA, 8'h09, 8'h00, 3, 1'b1);
    exp_cnt++;
    expect_out(0, 0, 0, 0, 0, "R3 cared bit differs rejected");
    expect_cnt("R7 count after cared-bit reject");
    wr(0, 16'h00FF); wr(1, 16'h1255);
    frame(8'h55, 8'h99, 8'h44, 8'h00, 3, 1'b1);
    expect_out(8'h55, 8'h99, 8'h44, 0, 3, "R8 8-bit match upper ignored");
    frame(8'h56, 8'h12, 8'h44, 8'h00, 3, 1'b1);
    exp_cnt++;
    expect_out(0, 0, 0, 0, 0, "R8 8-bit low byte differs");
    expect_cnt("R8 count");
    wr(0, 16'hFFFF);
  endtask

  task automatic t_short;
    frame(8'h68, 8'h00, 8'h00, 8'h00, 1, 1'b1);
    expect_out(0, 0, 0, 0, 0, "R9 short frame no output");
    expect_cnt("R9 short frame not counted");
  endtask

  task automatic t_restart;
    wr(1, 16'hAA68);
    got.delete(); last_seen = 0;
    put_byte(8'h33, 1'b1); put_byte(8'h44, 1'b0); put_byte(8'h55, 1'b0);
    put_byte(8'h68, 1'b1); put_byte(8'hAA, 1'b0); put_byte(8'h77, 1'b0);
    put_eof(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    expect_out(8'h68, 8'hAA, 8'h77, 0, 3, "R12 restart passes new frame");
    expect_cnt("R12 abandoned frame not counted");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) begin
      frame(8'h01, 8'h02, 8'h00, 8'h00, 2, 1'b1);
      if (exp_cnt < 15) exp_cnt++;
    end
    expect_cnt("R10 saturates at all-ones");
    got.delete(); last_seen = 0;
    put_byte(8'h01, 1'b1); put_byte(8'h02, 1'b0);
    put_eof(1'b1, 1'b1);
    exp_cnt = 0;
    expect_cnt("R11 clear wins over increment");
    frame(8'h01, 8'h02, 8'h00, 8'h00, 2, 1'b1);
    exp_cnt = 1;
    expect_cnt("R11 counts again after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_match16();
    t_reject_bad();
    t_mask();
    t_short();
    t_restart();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule